// File: doc/BRIEF.md
# Timing-Reference Detector and Near-Limit Clipper

This block conditions parallel video words on their way from the input register to the serial scrambler. Each clock it takes one word, widens it to ten bits if the source is an eight-bit one, and, while detection is enabled, pulls values that sit next to the reserved codes onto the reserved codes themselves. Words that a source with only eight significant bits produced as timing markers therefore reach the scrambler as exact ten-bit timing markers.

The block also watches the conditioned stream for the three-word timing preamble (all ones, then two all-zero words). It raises a found flag alongside the word that follows the preamble, and marks that word as a start-of-line or end-of-line marker from one of its bits. Word and flags leave the block together after a fixed two-clock delay, so the encoder downstream can tell timing words from picture data without any realignment.

Top module: `trs_conditioner`

## Requirements
- R1: While reset is asserted (rst_ni low), word_o is 0x000 and trs_found_o, sav_o and eav_o are low, whatever the inputs do.
- R2: The conditioned form of the word presented at a clock edge appears on word_o after exactly two rising edges, and its flags appear on the same cycle.
- R3: While detect_en_ni is low, an input word (after widening) in the range 0x000 to 0x003 leaves as 0x000; 0x004 is passed unchanged.
- R4: While detect_en_ni is low, a word in the range 0x3FC to 0x3FF leaves as 0x3FF; 0x3FB is passed unchanged.
- R5: While detect_en_ni is high, the word is passed without clipping (0x002 stays 0x002, 0x3FD stays 0x3FD) and trs_found_o, sav_o and eav_o stay low for that word, even after a complete preamble.
- R6: With narrow_mode_i high, the byte on word_i[9:2] is placed in bits 9..2 and bits 1..0 become zero before clipping; the levels on word_i[1:0] have no effect.
- R7: trs_found_o is high on the cycle a word is output when, with detection enabled for that word, the three conditioned words before it were 0x3FF, 0x000, 0x000 in that order.
- R8: On a flagged word, bit 4 of the word selects the marker type: 1 raises eav_o, 0 raises sav_o; neither is ever high without trs_found_o, and never both.
- R9: Because clipping precedes detection, a near-limit preamble such as 0x3FD, 0x001, 0x003 or an eight-bit preamble of bytes 0xFF, 0x00, 0x00 is recognised as a timing reference.
- R10: No flag is raised for any sequence other than the full preamble (for example 0x3FF, 0x000, 0x004), and trs_found_o is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 10 | Parallel input word; in narrow mode the byte occupies bits 9..2 |
| narrow_mode_i | input | 1 | High selects eight-bit input words |
| detect_en_ni | input | 1 | Low enables clipping and preamble detection |
| word_o | output | 10 | Conditioned word, two cycles after input |
| trs_found_o | output | 1 | High with the word that follows a timing preamble |
| sav_o | output | 1 | Flagged word is a start-of-active-video marker |
| eav_o | output | 1 | Flagged word is an end-of-active-video marker |

## Verification
The bench drives the exact range edges on both sides of each clip window (0x003/0x004 and 0x3FB/0x3FC), where an off-by-one comparison would either leave a near-reserved code in the stream or damage a legal picture value. It sends preambles built from near-limit and eight-bit values, which a design that detected before clipping would miss, and near-miss preambles and disabled-detection preambles, which a loose matcher or an ignored enable would flag. Stray levels on the two low input lines in narrow mode expose a widening that forgot to zero them, and long random runs biased toward the limits catch any misaligned flag, since a flag one cycle early or late lands on a preamble word instead of the marker.

// File: rtl/trs_pkg.sv
package trs_pkg;

    // Flags that travel with each conditioned word.
    typedef struct packed {
        logic found;
        logic sav;
        logic eav;
    } trs_flags_t;

    localparam trs_flags_t TRS_FLAGS_NONE = '{found: 1'b0, sav: 1'b0, eav: 1'b0};

endpackage

// File: rtl/trs_widen.sv
// Places an eight-bit word in the upper lanes of the full-width word.
module trs_widen #(
    parameter int DATA_W   = 10,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] wide_o
);
    localparam int PAD_W = DATA_W - NARROW_W;

    generate
        if (PAD_W == 0) begin : g_same_width
            logic unused_narrow;
            assign unused_narrow = narrow_i;
            assign wide_o = raw_i;
        end else begin : g_pad_low
            always_comb begin
                if (narrow_i) begin
                    wide_o = {raw_i[DATA_W-1:PAD_W], {PAD_W{1'b0}}};
                end else begin
                    wide_o = raw_i;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/trs_clip.sv
// Folds values that lie near either reserved limit onto the limit itself.
module trs_clip #(
    parameter int DATA_W    = 10,
    parameter int CLIP_SPAN = 4
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              enable_i,
    output logic [DATA_W-1:0] word_o
);
    localparam logic [DATA_W-1:0] TOP_VAL  = '1;
    localparam logic [DATA_W-1:0] LOW_LIM  = DATA_W'(CLIP_SPAN - 1);
    localparam logic [DATA_W-1:0] HIGH_LIM = TOP_VAL - DATA_W'(CLIP_SPAN - 1);

    always_comb begin
        word_o = word_i;
        if (enable_i) begin
            if (word_i <= LOW_LIM) begin
                word_o = '0;
            end else if (word_i >= HIGH_LIM) begin
                word_o = TOP_VAL;
            end
        end
    end

endmodule

// File: rtl/trs_detect.sv
// Keeps the last three conditioned words and recognises the preamble
// (all ones, then zeros) in front of the word currently presented.
module trs_detect
    import trs_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int ID_BIT = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] word_i,
    input  logic              enable_i,
    output trs_flags_t        flags_o
);
    localparam int PRE_LEN = 3;
    localparam logic [DATA_W-1:0] ONES = '1;

    typedef struct packed {
        logic [PRE_LEN-1:0][DATA_W-1:0] hist;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       pre_ok;

    always_comb begin
        st_d = st_q;
        st_d.hist[0] = word_i;
        for (int k = 1; k < PRE_LEN; k++) begin
            st_d.hist[k] = st_q.hist[k-1];
        end

        pre_ok = (st_q.hist[PRE_LEN-1] == ONES);
        for (int k = 0; k < PRE_LEN - 1; k++) begin
            if (st_q.hist[k] != '0) begin
                pre_ok = 1'b0;
            end
        end

        flags_o       = TRS_FLAGS_NONE;
        flags_o.found = enable_i && pre_ok;
        flags_o.sav   = flags_o.found && !word_i[ID_BIT];
        flags_o.eav   = flags_o.found &&  word_i[ID_BIT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a found flag implies the first preamble word arrived three words back.
    assert_preamble_head_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flags_o.found |-> ($past(word_i, PRE_LEN) == ONES));

    // R5: detection never reports while disabled for the current word.
    assert_enable_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |-> !flags_o.found);

endmodule

// File: rtl/trs_conditioner.sv
module trs_conditioner
    import trs_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int NARROW_W  = 8,
    parameter int CLIP_SPAN = 4,
    parameter int ID_BIT    = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] word_i,
    input  logic              narrow_mode_i,
    input  logic              detect_en_ni,
    output logic [DATA_W-1:0] word_o,
    output logic              trs_found_o,
    output logic              sav_o,
    output logic              eav_o
);
    localparam logic [DATA_W-1:0] TOP_VAL  = '1;
    localparam logic [DATA_W-1:0] LOW_LIM  = DATA_W'(CLIP_SPAN - 1);
    localparam logic [DATA_W-1:0] HIGH_LIM = TOP_VAL - DATA_W'(CLIP_SPAN - 1);

    typedef struct packed {
        logic [DATA_W-1:0] s1_word;
        logic              s1_en;
        logic [DATA_W-1:0] out_word;
        logic              out_en;
        trs_flags_t        flags;
        logic [1:0]        prime;
    } cond_state_t;

    cond_state_t       st_d, st_q;
    logic [DATA_W-1:0] wide_word;
    logic [DATA_W-1:0] cond_word;
    logic              det_on;
    trs_flags_t        det_flags;

    assign det_on = !detect_en_ni;

    trs_widen #(
        .DATA_W   (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_widen (
        .raw_i    (word_i),
        .narrow_i (narrow_mode_i),
        .wide_o   (wide_word)
    );

    trs_clip #(
        .DATA_W    (DATA_W),
        .CLIP_SPAN (CLIP_SPAN)
    ) u_clip (
        .word_i   (wide_word),
        .enable_i (det_on),
        .word_o   (cond_word)
    );

    trs_detect #(
        .DATA_W (DATA_W),
        .ID_BIT (ID_BIT)
    ) u_detect (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .word_i   (st_q.s1_word),
        .enable_i (st_q.s1_en),
        .flags_o  (det_flags)
    );

    always_comb begin
        st_d          = st_q;
        st_d.s1_word  = cond_word;
        st_d.s1_en    = det_on;
        st_d.out_word = st_q.s1_word;
        st_d.out_en   = st_q.s1_en;
        st_d.flags    = det_flags;
        st_d.prime    = {st_q.prime[0], 1'b1};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o      = st_q.out_word;
    assign trs_found_o = st_q.flags.found;
    assign sav_o       = st_q.flags.sav;
    assign eav_o       = st_q.flags.eav;

    // R2: two-edge latency from the clipper output to the port.
    assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.prime == 2'b11) |-> (word_o == $past(cond_word, 2)));

    // R3: with detection on, nothing in the low clip window survives.
    assert_clip_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.out_en && word_o != '0) |-> (word_o > LOW_LIM));

    // R4: with detection on, nothing in the high clip window survives.
    assert_clip_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.out_en && word_o != TOP_VAL) |-> (word_o < HIGH_LIM));

    // R5: a word that passed with detection off carries no flag.
    assert_bypass_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.out_en |-> !(trs_found_o || sav_o || eav_o));

    // R6: narrow words leave with zero low bits unless folded to all ones.
    assert_narrow_pad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.prime == 2'b11 && $past(narrow_mode_i, 2) && word_o != TOP_VAL)
        |-> (word_o[DATA_W-NARROW_W-1:0] == '0));

    // R8: marker type only with a found flag, and exclusive.
    assert_marker_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sav_o || eav_o) |-> (trs_found_o && !(sav_o && eav_o)));

    // R8: marker type follows the identifying bit of the output word.
    assert_marker_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trs_found_o |-> (eav_o == word_o[ID_BIT]));

    // R10: a found flag is never followed directly by another.
    assert_flag_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trs_found_o |=> !trs_found_o);

endmodule

// File: tb/trs_conditioner_bench.sv
`timescale 1ns/1ps
module trs_conditioner_bench;

    logic       clk;
    logic       rst_n;
    logic [9:0] word_in;
    logic       narrow;
    logic       det_off;
    logic [9:0] word_out;
    logic       found, sav, eav;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Bench model state: last three conditioned words and a two-deep pipe.
    logic [9:0] mh1 = '0, mh2 = '0, mh3 = '0;
    logic [9:0] pw [2];
    logic [2:0] pf [2];
    string      ptag [2];
    int         filled = 0;

    trs_conditioner u_trs_conditioner (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .word_i        (word_in),
        .narrow_mode_i (narrow),
        .detect_en_ni  (det_off),
        .word_o        (word_out),
        .trs_found_o   (found),
        .sav_o         (sav),
        .eav_o         (eav)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [9:0] cond_fn(logic [9:0] w, bit nar, bit dis);
        logic [9:0] v;
        v = nar ? {w[9:2], 2'b00} : w;
        if (!dis) begin
            if (v <= 10'h003)      v = 10'h000;
            else if (v >= 10'h3FC) v = 10'h3FF;
        end
        return v;
    endfunction

    // Checks the word driven two steps ago, then drives a new one.
    task automatic step(input logic [9:0] w, input bit nar, input bit dis, input string tag);
        logic [9:0] c;
        bit         t;
        if (filled >= 2) begin
            checks++;
            if (word_out !== pw[1] || {found, sav, eav} !== pf[1]) begin
                errors++;
                $display("FAIL %s: word=%h flags=%b expected word=%h flags=%b",
                         ptag[1], word_out, {found, sav, eav}, pw[1], pf[1]);
            end
        end
        c = cond_fn(w, nar, dis);
        t = !dis && mh3 == 10'h3FF && mh2 == 10'h000 && mh1 == 10'h000;
        pw[1] = pw[0]; pf[1] = pf[0]; ptag[1] = ptag[0];
        pw[0] = c;
        pf[0] = {t, t && !c[4], t && c[4]};
        ptag[0] = tag;
        mh3 = mh2; mh2 = mh1; mh1 = c;
        filled++;
        word_in = w; narrow = nar; det_off = dis;
        @(negedge clk);
    endtask

    task automatic expect_flag(input bit exp_found, input bit exp_eav, input string tag);
        // Used right after the marker step plus one extra step: marker is on the port now.
        checks++;
        if (found !== exp_found || (exp_found && eav !== exp_eav)) begin
            errors++;
            $display("FAIL %s: found=%b eav=%b expected found=%b eav=%b",
                     tag, found, eav, exp_found, exp_eav);
        end
    endtask

    task automatic preamble(input logic [9:0] a, input logic [9:0] b, input logic [9:0] c2,
                            input logic [9:0] xyz, input bit nar, input bit dis, input string tag);
        step(a, nar, dis, tag);
        step(b, nar, dis, tag);
        step(c2, nar, dis, tag);
        step(xyz, nar, dis, tag);
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'h5EED0207);
        rst_n = 1'b0; word_in = 10'h3FF; narrow = 1'b0; det_off = 1'b0;
        repeat (3) @(negedge clk);
        word_in = 10'h274;
        @(negedge clk);
        checks++;
        if (word_out !== 10'h000 || {found, sav, eav} !== 3'b000) begin
            errors++;
            $display("FAIL R1: word=%h flags=%b expected word=000 flags=000",
                     word_out, {found, sav, eav});
        end
        rst_n = 1'b1;

        // R3 low window edges
        step(10'h000, 0, 0, "R3"); step(10'h001, 0, 0, "R3");
        step(10'h002, 0, 0, "R3"); step(10'h003, 0, 0, "R3");
        step(10'h004, 0, 0, "R3");
        // R4 high window edges
        step(10'h3FB, 0, 0, "R4"); step(10'h3FC, 0, 0, "R4");
        step(10'h3FD, 0, 0, "R4"); step(10'h3FE, 0, 0, "R4");
        step(10'h3FF, 0, 0, "R4");
        // R5 bypass: no clipping, no flag after a full preamble
        step(10'h002, 0, 1, "R5"); step(10'h3FD, 0, 1, "R5");
        preamble(10'h3FF, 10'h000, 10'h000, 10'h274, 0, 1, "R5");
        step(10'h155, 0, 0, "R5");
        expect_flag(0, 0, "R5");
        // R6 narrow widening with stray low lines
        step(10'h203, 1, 0, "R6"); step(10'h2AA, 1, 1, "R6");
        step(10'h001, 1, 1, "R6"); step(10'h3FE, 1, 1, "R6");
        // R7/R8 exact preambles, both marker types
        preamble(10'h3FF, 10'h000, 10'h000, 10'h200, 0, 0, "R7");
        step(10'h080, 0, 0, "R7");
        expect_flag(1, 0, "R8 sav");
        preamble(10'h3FF, 10'h000, 10'h000, 10'h274, 0, 0, "R8");
        step(10'h080, 0, 0, "R8");
        expect_flag(1, 1, "R8 eav");
        // R9 near-limit and eight-bit preambles
        preamble(10'h3FD, 10'h001, 10'h003, 10'h2D8, 0, 0, "R9");
        step(10'h100, 0, 0, "R9");
        expect_flag(1, 1, "R9 near-limit");
        preamble(10'h3FC, 10'h003, 10'h002, 10'h274, 1, 0, "R9");
        step(10'h100, 1, 0, "R9");
        expect_flag(1, 1, "R9 eight-bit");
        // R10 near misses
        preamble(10'h3FF, 10'h000, 10'h004, 10'h274, 0, 0, "R10");
        step(10'h100, 0, 0, "R10");
        expect_flag(0, 0, "R10 near miss");
        preamble(10'h3FB, 10'h000, 10'h000, 10'h274, 0, 0, "R10");
        step(10'h100, 0, 0, "R10");
        expect_flag(0, 0, "R10 low head");

        // R2 random traffic biased to the limits, with embedded preambles
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            logic [9:0]  w;
            bit          nar, dis;
            r   = $urandom % 16;
            nar = ($urandom % 4) == 0;
            dis = ($urandom % 8) == 0;
            if (r == 0) begin
                preamble(10'h3FC | 10'($urandom % 4), 10'($urandom % 4), 10'($urandom % 4),
                         10'($urandom), nar, dis, "R2 pre");
            end else begin
                case ($urandom % 4)
                    0:       w = 10'($urandom % 6);
                    1:       w = 10'h3FA + 10'($urandom % 6);
                    default: w = 10'($urandom);
                endcase
                step(w, nar, dis, "R2");
            end
        end
        // flush the pipe so the last words are checked
        step(10'h100, 0, 0, "R2"); step(10'h100, 0, 0, "R2");
        step(10'h100, 0, 0, "R2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule